// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides which interrupt a 16550-style UART reports and whether its interrupt line is asserted. It receives status events from the rest of the UART: receive line errors, receive data readiness, receive FIFO occupancy and traffic, transmit-empty events, modem-line changes, and writes to the line-control register made while the UART is busy. It also receives strobes that mark software reads and writes of the UART registers. From these it keeps the pending sources, selects the one with the highest priority, and drives a 4-bit identity code and an interrupt request.

Most sources are sticky. An event sets them, and a particular register access clears them. The receive data source is a level taken from the buffer or the FIFO. The character timeout comes from an internal counter. That counter measures four character times in baud ticks, and the length of one character follows the programmed word length, the parity enable and the stop-bit count. Bit serialization, baud-rate generation and FIFO storage are done outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset no source is pending, so `intId` reads 4'b0001 (nothing pending).
- R2: `irq` is high exactly when `intId` is not 4'b0001.
- R3: A `lineErrEvt` pulse makes `intId` read 4'b0110 from the next cycle. It stays that way until a `rdLsr` strobe, and it overrides every other source.
- R4: The receive data source reads 4'b0100 in the same cycle as its level input. It follows `rxBufFull` when `fifoEn` is low and `rxTrigHit` when `fifoEn` is high. When both are pending, it wins over the character timeout.
- R5: With `fifoEn` high and `rxNotEmpty` high, `intId` reads 4'b1100 once four character times of baud ticks have passed without an `rxPush`, `rxPop` or `rdRbr`. Any of those three restarts the count and clears the timeout.
- R6: One character time is (1 start + data bits + `lcrParityEn` + 1 stop + `lcrStopTwo`) bits times TICKS_PER_BIT baud ticks. `lcrWordLen` selects the data bits: 00, 01, 10 and 11 give 5, 6, 7 and 8.
- R7: A `thrEmptyEvt` pulse makes the transmit-empty source pending (4'b0010). A `wrThr` clears it. A `rdIir` clears it only in a cycle where `intId` reads 4'b0010; a `rdIir` in any other cycle leaves it pending.
- R8: A `modemChgEvt` pulse makes the modem source pending (4'b0000). A `rdMsr` clears it.
- R9: An `lcrWrite` while `busyStatus` is high makes busy detect pending (4'b0111). An `lcrWrite` while `busyStatus` is low has no effect. A `rdUsr` clears busy detect.
- R10: Priority from highest to lowest is: line status, receive data, character timeout, transmit empty, modem status, busy detect.
- R11: When a sticky source receives its set event and its clear strobe in the same cycle, it stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | FIFO mode enabled |
| lcrWordLen | input | 2 | Word length select from the line-control register |
| lcrParityEn | input | 1 | Parity bit present in each character |
| lcrStopTwo | input | 1 | Two stop bits instead of one |
| baudTick | input | 1 | One baud-rate tick |
| rxBufFull | input | 1 | Receive holding buffer full (non-FIFO mode) |
| rxTrigHit | input | 1 | Receive FIFO at or above its trigger level |
| rxNotEmpty | input | 1 | Receive FIFO holds at least one character |
| rxPush | input | 1 | Character written into the receive FIFO |
| rxPop | input | 1 | Character taken from the receive FIFO |
| lineErrEvt | input | 1 | Overrun, parity, framing or break event |
| thrEmptyEvt | input | 1 | Transmit holding register or FIFO reached empty/threshold |
| modemChgEvt | input | 1 | Change seen on a modem input line |
| lcrWrite | input | 1 | Write to the line-control register |
| busyStatus | input | 1 | UART busy status bit |
| rdLsr | input | 1 | Read of the line status register |
| rdRbr | input | 1 | Read of the receive buffer register |
| rdIir | input | 1 | Read of the interrupt identity register |
| rdMsr | input | 1 | Read of the modem status register |
| rdUsr | input | 1 | Read of the UART status register |
| wrThr | input | 1 | Write of the transmit holding register |
| intId | output | 4 | Identity of the highest pending source |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a character timeout that lands on a known cycle while other sources are also pending. Reaching it needs a held FIFO level, an uninterrupted stream of baud ticks, and a limit that moves with three line-control fields. The stimulus pushes one character and then holds `rxNotEmpty` with ticks running, once for the shortest character and once for the longest. A reference model that counts ticks finds the exact cycle at which the code moves to 4'b1100. The bench then raises the trigger level over a pending timeout and reads the identity register while line status is pending, to show that the priority masks a source without clearing it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ID_W = 4;

  localparam logic [ID_W-1:0] ID_NONE   = 4'h1;
  localparam logic [ID_W-1:0] ID_LINE   = 4'h6;
  localparam logic [ID_W-1:0] ID_RXDATA = 4'h4;
  localparam logic [ID_W-1:0] ID_RXTO   = 4'hC;
  localparam logic [ID_W-1:0] ID_THRE   = 4'h2;
  localparam logic [ID_W-1:0] ID_MODEM  = 4'h0;
  localparam logic [ID_W-1:0] ID_BUSY   = 4'h7;

  // Longest character: start + 8 data + parity + 2 stop.
  localparam int MAX_CHAR_BITS = 12;
  localparam int TO_CHARS      = 4;

  typedef struct packed {
    logic clrLine;
    logic clrRxTo;
    logic clrThre;
    logic clrModem;
    logic clrBusy;
  } clrStrobes_t;
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic            fifoEn,
  input  logic            rxBufFull,
  input  logic            rxTrigHit,
  input  logic            lcrWrite,
  input  logic            busyStatus,
  input  logic            rdLsr,
  input  logic            rdRbr,
  input  logic            rdIir,
  input  logic            rdMsr,
  input  logic            rdUsr,
  input  logic            wrThr,
  input  logic [ID_W-1:0] curId,
  output clrStrobes_t     strb,
  output logic            busyViolEvt,
  output logic            rxDataHit
);
  always_comb begin
    strb.clrLine  = rdLsr;
    strb.clrRxTo  = rdRbr;
    strb.clrModem = rdMsr;
    strb.clrBusy  = rdUsr;
    // An identity read clears transmit-empty only while it is the source being shown.
    strb.clrThre  = wrThr | (rdIir & (curId == ID_THRE));
  end

  assign busyViolEvt = lcrWrite & busyStatus;
  assign rxDataHit   = fifoEn ? rxTrigHit : rxBufFull;
endmodule

// File: rtl/uart_irq_dpath.sv
module uart_irq_dpath
  import uart_irq_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fifoEn,
  input  logic [1:0]      wordLen,
  input  logic            parityEn,
  input  logic            twoStop,
  input  logic            baudTick,
  input  logic            rxNotEmpty,
  input  logic            rxPush,
  input  logic            rxPop,
  input  logic            rxDataHit,
  input  logic            lineErrEvt,
  input  logic            thrEmptyEvt,
  input  logic            modemChgEvt,
  input  logic            busyViolEvt,
  input  clrStrobes_t     strb,
  output logic [ID_W-1:0] intId
);
  localparam int LIMIT_MAX = TO_CHARS * MAX_CHAR_BITS * TICKS_PER_BIT;
  localparam int CNT_W     = $clog2(LIMIT_MAX + 1);
  localparam int N_STICKY  = 4;

  // Sticky sources: [0] line, [1] modem, [2] busy, [3] transmit empty.
  logic [N_STICKY-1:0] stSet, stClr, stPend;
  assign stSet = {thrEmptyEvt, busyViolEvt, modemChgEvt, lineErrEvt};
  assign stClr = {strb.clrThre, strb.clrBusy, strb.clrModem, strb.clrLine};

  for (genvar g = 0; g < N_STICKY; g++) begin : gSticky
    always_ff @(posedge clk) begin
      if (!rstN)          stPend[g] <= 1'b0;
      else if (stSet[g])  stPend[g] <= 1'b1;
      else if (stClr[g])  stPend[g] <= 1'b0;
    end
  end

  // Character-time timeout counter.
  logic [3:0]       charBits;
  logic [CNT_W-1:0] toLimit, toCnt;
  logic             toRestart, rxTimeout;

  assign charBits  = 4'd7 + {2'b00, wordLen} + {3'b000, parityEn} + {3'b000, twoStop};
  assign toLimit   = CNT_W'(charBits) * CNT_W'(TO_CHARS * TICKS_PER_BIT);
  assign toRestart = strb.clrRxTo | rxPush | rxPop | ~rxNotEmpty | ~fifoEn;

  always_ff @(posedge clk) begin
    if (!rstN || toRestart)              toCnt <= '0;
    else if (baudTick && toCnt < toLimit) toCnt <= toCnt + 1'b1;
  end

  assign rxTimeout = fifoEn & rxNotEmpty & (toCnt >= toLimit);

  always_comb begin
    if      (stPend[0]) intId = ID_LINE;
    else if (rxDataHit) intId = ID_RXDATA;
    else if (rxTimeout) intId = ID_RXTO;
    else if (stPend[3]) intId = ID_THRE;
    else if (stPend[1]) intId = ID_MODEM;
    else if (stPend[2]) intId = ID_BUSY;
    else                intId = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoEn,
  input  logic [1:0] lcrWordLen,
  input  logic       lcrParityEn,
  input  logic       lcrStopTwo,
  input  logic       baudTick,
  input  logic       rxBufFull,
  input  logic       rxTrigHit,
  input  logic       rxNotEmpty,
  input  logic       rxPush,
  input  logic       rxPop,
  input  logic       lineErrEvt,
  input  logic       thrEmptyEvt,
  input  logic       modemChgEvt,
  input  logic       lcrWrite,
  input  logic       busyStatus,
  input  logic       rdLsr,
  input  logic       rdRbr,
  input  logic       rdIir,
  input  logic       rdMsr,
  input  logic       rdUsr,
  input  logic       wrThr,
  output logic [3:0] intId,
  output logic       irq
);
  clrStrobes_t strb;
  logic        busyViolEvt, rxDataHit;

  uart_irq_ctrl ctrl_i (
    .fifoEn(fifoEn), .rxBufFull(rxBufFull), .rxTrigHit(rxTrigHit),
    .lcrWrite(lcrWrite), .busyStatus(busyStatus),
    .rdLsr(rdLsr), .rdRbr(rdRbr), .rdIir(rdIir), .rdMsr(rdMsr),
    .rdUsr(rdUsr), .wrThr(wrThr), .curId(intId),
    .strb(strb), .busyViolEvt(busyViolEvt), .rxDataHit(rxDataHit)
  );

  uart_irq_dpath #(.TICKS_PER_BIT(TICKS_PER_BIT)) dpath_i (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .wordLen(lcrWordLen),
    .parityEn(lcrParityEn), .twoStop(lcrStopTwo), .baudTick(baudTick),
    .rxNotEmpty(rxNotEmpty), .rxPush(rxPush), .rxPop(rxPop),
    .rxDataHit(rxDataHit), .lineErrEvt(lineErrEvt), .thrEmptyEvt(thrEmptyEvt),
    .modemChgEvt(modemChgEvt), .busyViolEvt(busyViolEvt), .strb(strb),
    .intId(intId)
  );

  assign irq = (intId != ID_NONE);
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rstN,
  input logic       fifoEn,
  input logic       rxBufFull,
  input logic       rxNotEmpty,
  input logic       lineErrEvt,
  input logic       thrEmptyEvt,
  input logic       modemChgEvt,
  input logic       rdLsr,
  input logic       rdUsr,
  input logic [3:0] intId,
  input logic       irq
);
  assert_irq_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    irq == (intId != 4'h1));

  assert_line_raise_R3: assert property (@(posedge clk) disable iff (!rstN)
    lineErrEvt |=> intId == 4'h6);

  assert_line_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (intId == 4'h6 && !rdLsr) |=> intId == 4'h6);

  assert_rxdata_nofifo_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && rxBufFull && intId != 4'h6) |-> intId == 4'h4);

  assert_timeout_cond_R5: assert property (@(posedge clk) disable iff (!rstN)
    intId == 4'hC |-> (fifoEn && rxNotEmpty));

  assert_thre_raise_R7: assert property (@(posedge clk) disable iff (!rstN)
    thrEmptyEvt |=> irq);

  assert_modem_raise_R8: assert property (@(posedge clk) disable iff (!rstN)
    modemChgEvt |=> irq);

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (intId == 4'h7 && !rdUsr) |=> irq);
endmodule

bind uart_irq_ident uart_irq_ident_chk chk_i (
  .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .rxBufFull(rxBufFull),
  .rxNotEmpty(rxNotEmpty), .lineErrEvt(lineErrEvt), .thrEmptyEvt(thrEmptyEvt),
  .modemChgEvt(modemChgEvt), .rdLsr(rdLsr), .rdUsr(rdUsr),
  .intId(intId), .irq(irq)
);

// File: tb/uart_irq_ident_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;
  localparam int TPB = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEn = 0, lcrParityEn = 0, lcrStopTwo = 0, baudTick = 0;
  logic [1:0] lcrWordLen = 2'b11;
  logic rxBufFull = 0, rxTrigHit = 0, rxNotEmpty = 0, rxPush = 0, rxPop = 0;
  logic lineErrEvt = 0, thrEmptyEvt = 0, modemChgEvt = 0, lcrWrite = 0, busyStatus = 0;
  logic rdLsr = 0, rdRbr = 0, rdIir = 0, rdMsr = 0, rdUsr = 0, wrThr = 0;
  logic [3:0] intId;
  logic irq;

  int total = 0, bad = 0;
  bit done = 0;

  // Reference model state
  bit mLine, mModem, mBusy, mThre;
  int mCnt;

  always #4 clk = ~clk;

  uart_irq_ident #(.TICKS_PER_BIT(TPB)) dut_i (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .lcrWordLen(lcrWordLen),
    .lcrParityEn(lcrParityEn), .lcrStopTwo(lcrStopTwo), .baudTick(baudTick),
    .rxBufFull(rxBufFull), .rxTrigHit(rxTrigHit), .rxNotEmpty(rxNotEmpty),
    .rxPush(rxPush), .rxPop(rxPop), .lineErrEvt(lineErrEvt),
    .thrEmptyEvt(thrEmptyEvt), .modemChgEvt(modemChgEvt), .lcrWrite(lcrWrite),
    .busyStatus(busyStatus), .rdLsr(rdLsr), .rdRbr(rdRbr), .rdIir(rdIir),
    .rdMsr(rdMsr), .rdUsr(rdUsr), .wrThr(wrThr), .intId(intId), .irq(irq)
  );

  function automatic int charTicks();  // R6
    int bits = 1 + (5 + int'(lcrWordLen)) + int'(lcrParityEn) + 1 + int'(lcrStopTwo);
    return 4 * bits * TPB;
  endfunction

  function automatic int modelId();  // R10 priority order
    bit rxData = fifoEn ? rxTrigHit : rxBufFull;
    bit toHit  = fifoEn && rxNotEmpty && (mCnt >= charTicks());
    if (mLine)  return 6;
    if (rxData) return 4;
    if (toHit)  return 12;
    if (mThre)  return 2;
    if (mModem) return 0;
    if (mBusy)  return 7;
    return 1;
  endfunction

  function automatic string reqOf(int id);
    case (id)
      6: return "R3";  4: return "R4";  12: return "R5";
      2: return "R7";  0: return "R8";  7: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelAdvance();
    int id = modelId();
    bit rst = !fifoEn || !rxNotEmpty || rxPush || rxPop || rdRbr;
    if (!rstN) begin
      mLine = 0; mModem = 0; mBusy = 0; mThre = 0; mCnt = 0;
      return;
    end
    if (lineErrEvt) mLine = 1; else if (rdLsr) mLine = 0;
    if (modemChgEvt) mModem = 1; else if (rdMsr) mModem = 0;
    if (lcrWrite && busyStatus) mBusy = 1; else if (rdUsr) mBusy = 0;
    if (thrEmptyEvt) mThre = 1; else if (wrThr || (rdIir && id == 2)) mThre = 0;
    if (rst) mCnt = 0;
    else if (baudTick && mCnt < charTicks()) mCnt++;
  endtask

  // One cycle: compare outputs against the model, advance, then drop pulses.
  task automatic step();
    int e;
    #1;
    if (rstN) begin
      e = modelId();
      chk(reqOf(e), int'(intId), e);
      chk("R2", int'(irq), int'(e != 1));
    end
    modelAdvance();
    @(posedge clk);
    @(negedge clk);
    rxPush = 0; rxPop = 0; lineErrEvt = 0; thrEmptyEvt = 0; modemChgEvt = 0;
    lcrWrite = 0; rdLsr = 0; rdRbr = 0; rdIir = 0; rdMsr = 0; rdUsr = 0; wrThr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic expectId(string tag, int exp);
    #1;
    chk(tag, int'(intId), exp);
  endtask

  initial begin
    mLine = 0; mModem = 0; mBusy = 0; mThre = 0; mCnt = 0;
    @(negedge clk);
    idle(3);
    rstN = 1;
    expectId("R1", 1);
    chk("R1", int'(irq), 0);
    idle(2);

    // R3 line status outranks modem; modem shows after line status read
    lineErrEvt = 1; modemChgEvt = 1; step();
    expectId("R3", 6);
    idle(3);
    rdIir = 1; step();          // identity read must not clear line status
    expectId("R3", 6);
    rdLsr = 1; step();
    expectId("R8", 0);
    rdMsr = 1; step();
    expectId("R8", 1);

    // R11 set and clear in the same cycle
    lineErrEvt = 1; rdLsr = 1; step();
    expectId("R11", 6);
    rdLsr = 1; step();

    // R4 non-FIFO receive data, immediate
    fifoEn = 0; rxBufFull = 1; #1; expectId("R4", 4);
    step();
    lineErrEvt = 1; step();
    expectId("R10", 6);
    rdLsr = 1; step();
    expectId("R4", 4);
    rxBufFull = 0; idle(1);

    // R4 FIFO mode: buffer-full ignored, trigger level used
    fifoEn = 1; rxBufFull = 1; idle(2);
    expectId("R4", 1);
    rxTrigHit = 1; idle(1);
    expectId("R4", 4);
    rxTrigHit = 0; rxBufFull = 0; idle(1);

    // R5/R6 shortest character: 5 bits, no parity, one stop
    lcrWordLen = 2'b00; lcrParityEn = 0; lcrStopTwo = 0;
    rxNotEmpty = 1; rxPush = 1; baudTick = 1; step();
    idle(4 * 7 * TPB + 2);
    expectId("R6", 12);
    rxTrigHit = 1; idle(1);       // receive data outranks timeout
    expectId("R4", 4);
    rxTrigHit = 0; idle(1);
    rdRbr = 1; step();
    expectId("R5", 1);
    idle(10);
    rxPop = 1; step();            // restart midway
    idle(4 * 7 * TPB - 3);
    expectId("R5", 1);
    idle(4);
    expectId("R5", 12);
    rdRbr = 1; step();

    // R6 longest character: 8 bits, parity, two stop
    lcrWordLen = 2'b11; lcrParityEn = 1; lcrStopTwo = 1;
    idle(4 * 12 * TPB + 2);
    expectId("R6", 12);
    rxNotEmpty = 0; idle(1);
    expectId("R5", 1);
    baudTick = 0; idle(2);

    // R7 transmit empty and identity read
    thrEmptyEvt = 1; step();
    expectId("R7", 2);
    lineErrEvt = 1; step();
    rdIir = 1; step();            // shown id is line status; THRE must stay
    rdLsr = 1; step();
    expectId("R7", 2);
    rdIir = 1; step();
    expectId("R7", 1);
    thrEmptyEvt = 1; step();
    wrThr = 1; step();
    expectId("R7", 1);

    // R9 busy detect
    lcrWrite = 1; busyStatus = 0; step();
    expectId("R9", 1);
    busyStatus = 1; lcrWrite = 1; step();
    expectId("R9", 7);
    modemChgEvt = 1; step();
    expectId("R10", 0);
    rdMsr = 1; step();
    expectId("R9", 7);
    busyStatus = 0; rdUsr = 1; step();
    expectId("R9", 1);
    idle(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule